// File: doc/BRIEF.md
# Binary64 Round and Pack Unit

This block is the last step of a double-precision arithmetic datapath. An upstream adder, multiplier or divider produces a sign, a signed unbiased exponent and a normalized significand. That significand is extended with three extra low bits: guard, round and sticky. The block reduces this to a packed 64-bit binary64 word. It applies one of four rounding modes, treats results below the normal range either by gradual denormalization or by flushing to zero, and replaces results above the normal range with infinity or the largest finite value. Three exception flags come with the result: inexact, underflow and overflow.

The unit is a two-stage pipeline that accepts one operand per cycle. The first stage handles the small-exponent cases: flushing, the boundary case that stays normal after rounding, and the sticky right shift into the subnormal range. The second stage rounds, renormalizes, detects overflow and packs the word. Zero significands, NaNs and infinities are never presented to it.

Top module: `fp64_round_pack`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high, one result per accepted operand, back-to-back operands allowed. After reset `out_valid`, `out_result` and all flags are 0.
- R2: The input significand has bit 55 set as the hidden bit, bits 54..3 as the fraction and bits 2..0 as guard/round/sticky. When bits 2..0 are zero and the exponent lies in -1022..1023, the result is {sign, exponent+1023, bits 54..3} and no flag is set.
- R3: The mode is encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. When bits 2..0 are nonzero, inexact is set and the significand is increased before bits 2..0 are dropped. Nearest-even adds 3 plus bit 3. Toward zero adds nothing. Toward +infinity adds 8 for positive values only. Toward -infinity adds 8 for negative values only.
- R4: A rounding carry out of bit 55 shifts the significand right by one and raises the exponent by one.
- R5: A final exponent above 1023 sets overflow and inexact. The result is infinity (exponent field all ones, fraction 0) or the largest finite value (field 0x7FE, fraction all ones). Infinity is chosen for nearest-even, for toward +infinity with a positive sign, and for toward -infinity with a negative sign. The largest finite value is chosen in all other cases. The sign is always kept.
- R6: With `in_ftz` high and an exponent below -1022, the result is a signed zero with underflow and inexact set. The exceptions are toward +infinity with a positive sign and toward -infinity with a negative sign, which return the smallest subnormal (magnitude 1) with that sign. An exponent of -1022 or more is not affected by `in_ftz`.
- R7: With `in_ftz` low and an exponent below -1022, the significand is shifted right by (-1022 - exponent) and every bit shifted out is ORed into bit 0. Rounding then follows R3 at exponent -1022. A result whose bit 55 is clear before rounding and that is inexact also sets underflow. A result whose hidden bit is still clear after rounding is packed with exponent field 0.
- R8: At exponent -1023 with `in_ftz` low, if rounding the unshifted significand carries out of bit 55, the result is the smallest normal value (field 1, fraction 0). In that case only inexact is set.
- R9: An exact subnormal result sets underflow only when `in_uf_trap` is high. `in_uf_trap` has no effect on normal results.
- R10: A shift of 56 or more bits leaves only the sticky bit, so the result is 0 or the smallest subnormal, depending on mode and sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_sig | input | 56 | Hidden bit, fraction, guard/round/sticky |
| in_rmode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| in_ftz | input | 1 | Flush results below the normal range to zero |
| in_uf_trap | input | 1 | Flag underflow for exact subnormal results too |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Packed binary64 result |
| out_inexact | output | 1 | Result differs from the exact value |
| out_underflow | output | 1 | Tiny result |
| out_overflow | output | 1 | Result exceeded the finite range |

## Verification
Two pairs of functions can act on the same operand, and each pair is provoked directly. A significand of all ones at exponent 1023 makes the rounding carry push the exponent to 1024, so renormalization and overflow occur in the same cycle; the expected result is infinity with both overflow and inexact set. At exponent -1023 the rounding carry competes with the subnormal shift. The bench applies the same significand under nearest-even, where the carry wins and the smallest normal value comes out with only inexact set, and under toward-zero, where the shifted subnormal with underflow is expected. A further case rounds a shifted subnormal back up into the normal range.

// File: rtl/fp64_rp_pkg.sv
package fp64_rp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ix;
    logic uf;
    logic ov;
  } fflags_t;

endpackage

// File: rtl/rp_grs_inc.sv
module rp_grs_inc
  import fp64_rp_pkg::*;
#(
  parameter int SIG_W = 56
) (
  input  logic             sign,
  input  rmode_e           mode,
  input  logic [SIG_W-1:0] sig,
  output logic [SIG_W:0]   rnd
);

  // increment chosen from the three extra bits, kept LSB, mode and sign
  function automatic logic [3:0] grs_step(input logic s, input rmode_e m,
                                          input logic [3:0] low);
    logic [3:0] step;
    step = 4'd0;
    if (low[2:0] != 3'd0) begin
      case (m)
        RM_NEAR: step = 4'd3 + {3'd0, low[3]};
        RM_ZERO: step = 4'd0;
        RM_UP:   step = s ? 4'd0 : 4'd8;
        RM_DOWN: step = s ? 4'd8 : 4'd0;
        default: step = 4'd0;
      endcase
    end
    return step;
  endfunction

  always_comb begin
    rnd = {1'b0, sig} + (SIG_W+1)'(grs_step(sign, mode, sig[3:0]));
  end

endmodule

// File: rtl/rp_align.sv
module rp_align
  import fp64_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EFLD_W = 11,
  parameter int EIN_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic [EIN_W-1:0]        in_exp,
  input  logic [FRAC_W+3:0]       in_sig,
  input  rmode_e                  in_mode,
  input  logic                    in_ftz,
  input  logic                    in_trap,
  output logic                    a_valid,
  output logic                    a_sign,
  output logic signed [EIN_W+1:0] a_exp,
  output logic [FRAC_W+3:0]       a_sig,
  output rmode_e                  a_mode,
  output logic                    a_trap,
  output logic                    a_flush,
  output logic [FRAC_W+EFLD_W:0]  a_flush_res,
  output fflags_t                 a_flags
);

  localparam int SIG_W = FRAC_W + 4;
  localparam int TOT_W = 1 + EFLD_W + FRAC_W;
  localparam int IX_W  = EIN_W + 2;
  localparam int EBIAS = (1 << (EFLD_W - 1)) - 1;
  localparam logic signed [IX_W-1:0] EMIN_X = IX_W'(1 - EBIAS);

  // right shift that folds every lost bit into bit 0
  function automatic logic [SIG_W-1:0] sticky_shr(input logic [SIG_W-1:0] v,
                                                  input logic [IX_W-1:0] sh);
    logic [SIG_W-1:0] lostmask;
    if (sh >= IX_W'(SIG_W)) begin
      return {{(SIG_W-1){1'b0}}, |v};
    end
    lostmask = ~({SIG_W{1'b1}} << sh);
    return (v >> sh) | {{(SIG_W-1){1'b0}}, |(v & lostmask)};
  endfunction

  logic signed [IX_W-1:0] exp_x;
  logic [IX_W-1:0]        shamt;
  logic [SIG_W:0]         pre_rnd;
  logic                   ev_below;
  logic                   ev_flush;
  logic                   ev_edge_carry;
  logic                   flush_mag1;

  rp_grs_inc #(.SIG_W(SIG_W)) u_pre_rnd (
    .sign (in_sign),
    .mode (in_mode),
    .sig  (in_sig),
    .rnd  (pre_rnd)
  );

  always_comb begin
    exp_x         = IX_W'($signed(in_exp));
    shamt         = IX_W'(EMIN_X - exp_x);
    ev_below      = exp_x < EMIN_X;
    ev_flush      = ev_below && in_ftz;
    ev_edge_carry = ev_below && !in_ftz && (exp_x == EMIN_X - IX_W'(1)) && pre_rnd[SIG_W];
    flush_mag1    = (in_mode == RM_UP && !in_sign) || (in_mode == RM_DOWN && in_sign);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid     <= 1'b0;
      a_sign      <= 1'b0;
      a_exp       <= '0;
      a_sig       <= '0;
      a_mode      <= RM_NEAR;
      a_trap      <= 1'b0;
      a_flush     <= 1'b0;
      a_flush_res <= '0;
      a_flags     <= '0;
    end else begin
      a_valid     <= in_valid;
      a_sign      <= in_sign;
      a_mode      <= in_mode;
      a_trap      <= in_trap;
      a_flush     <= ev_flush;
      a_flush_res <= {in_sign, (TOT_W-2)'(0), flush_mag1};
      a_flags     <= '0;
      a_exp       <= exp_x;
      a_sig       <= in_sig;
      if (ev_flush) begin
        a_flags <= '{ix: 1'b1, uf: 1'b1, ov: 1'b0};
      end else if (ev_edge_carry) begin
        a_flags <= '{ix: 1'b1, uf: 1'b0, ov: 1'b0};
        a_sig   <= SIG_W'((pre_rnd >> 1) & ~(SIG_W+1)'(7));
        a_exp   <= EMIN_X;
      end else if (ev_below) begin
        a_sig   <= sticky_shr(in_sig, shamt);
        a_exp   <= EMIN_X;
      end
    end
  end

  // R7: a value below range without flushing always leaves this stage at the minimum exponent
  AST_BELOW_AT_EMIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ftz && ($signed(in_exp) < (1 - EBIAS)) |=> a_exp == EMIN_X); // R7

endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
  import fp64_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EFLD_W = 11,
  parameter int EIN_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_valid,
  input  logic                    a_sign,
  input  logic signed [EIN_W+1:0] a_exp,
  input  logic [FRAC_W+3:0]       a_sig,
  input  rmode_e                  a_mode,
  input  logic                    a_trap,
  input  logic                    a_flush,
  input  logic [FRAC_W+EFLD_W:0]  a_flush_res,
  input  fflags_t                 a_flags,
  output logic                    r_valid,
  output logic [FRAC_W+EFLD_W:0]  r_result,
  output fflags_t                 r_flags
);

  localparam int SIG_W = FRAC_W + 4;
  localparam int TOT_W = 1 + EFLD_W + FRAC_W;
  localparam int IX_W  = EIN_W + 2;
  localparam int EBIAS = (1 << (EFLD_W - 1)) - 1;
  localparam logic signed [IX_W-1:0] EMAX_X  = IX_W'(EBIAS);
  localparam logic signed [IX_W-1:0] EBIAS_X = IX_W'(EBIAS);

  logic [SIG_W:0]         rnd;
  logic [SIG_W:0]         post;
  logic [SIG_W:0]         norm;
  logic [FRAC_W:0]        kept;
  logic signed [IX_W-1:0] exp_f;
  logic                   ev_inexact;
  logic                   ev_carry;
  logic                   ev_ovf;
  logic                   ev_sub;
  logic                   to_inf;
  logic [TOT_W-1:0]       res_n;
  fflags_t                flg_n;

  rp_grs_inc #(.SIG_W(SIG_W)) u_fin_rnd (
    .sign (a_sign),
    .mode (a_mode),
    .sig  (a_sig),
    .rnd  (rnd)
  );

  always_comb begin
    ev_inexact = a_sig[2:0] != 3'd0;
    post       = ev_inexact ? rnd : {1'b0, a_sig};
    ev_carry   = post[SIG_W];
    norm       = ev_carry ? (post >> 1) : post;
    exp_f      = a_exp + (ev_carry ? IX_W'(1) : IX_W'(0));
    kept       = (FRAC_W+1)'(norm >> 3);
    ev_ovf     = exp_f > EMAX_X;
    ev_sub     = !kept[FRAC_W];
    to_inf     = (a_mode == RM_NEAR) || (a_mode == RM_UP && !a_sign) ||
                 (a_mode == RM_DOWN && a_sign);

    flg_n      = a_flags;
    flg_n.ix   = a_flags.ix | ev_inexact;
    flg_n.uf   = ev_inexact && !a_sig[SIG_W-1];
    if (a_flush) begin
      res_n = a_flush_res;
      flg_n = a_flags;
    end else if (ev_ovf) begin
      flg_n.ix = 1'b1;
      flg_n.ov = 1'b1;
      res_n = to_inf ? {a_sign, {EFLD_W{1'b1}}, {FRAC_W{1'b0}}}
                     : {a_sign, {(EFLD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (ev_sub) begin
      flg_n.uf = flg_n.uf | a_trap;
      res_n = {a_sign, {EFLD_W{1'b0}}, kept[FRAC_W-1:0]};
    end else begin
      res_n = {a_sign, EFLD_W'(exp_f + EBIAS_X), kept[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid  <= 1'b0;
      r_result <= '0;
      r_flags  <= '0;
    end else begin
      r_valid  <= a_valid;
      r_result <= res_n;
      r_flags  <= flg_n;
    end
  end

  AST_OVF_WITH_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_flags.ov |-> r_flags.ix); // R5
  AST_ALLONES_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && (r_result[TOT_W-2:FRAC_W] == {EFLD_W{1'b1}}) |-> r_flags.ov); // R5
  AST_TINY_INEXACT_UF: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && (r_result[TOT_W-2:FRAC_W] == '0) && r_flags.ix |-> r_flags.uf); // R7

endmodule

// File: rtl/fp64_round_pack.sv
module fp64_round_pack
  import fp64_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EFLD_W = 11,
  parameter int EIN_W  = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sign,
  input  logic [EIN_W-1:0]          in_exp,
  input  logic [FRAC_W+3:0]         in_sig,
  input  logic [1:0]                in_rmode,
  input  logic                      in_ftz,
  input  logic                      in_uf_trap,
  output logic                      out_valid,
  output logic [FRAC_W+EFLD_W:0]    out_result,
  output logic                      out_inexact,
  output logic                      out_underflow,
  output logic                      out_overflow
);

  localparam int SIG_W = FRAC_W + 4;
  localparam int TOT_W = 1 + EFLD_W + FRAC_W;
  localparam int IX_W  = EIN_W + 2;
  localparam int EBIAS = (1 << (EFLD_W - 1)) - 1;

  logic                   a_valid;
  logic                   a_sign;
  logic signed [IX_W-1:0] a_exp;
  logic [SIG_W-1:0]       a_sig;
  rmode_e                 a_mode;
  logic                   a_trap;
  logic                   a_flush;
  logic [TOT_W-1:0]       a_flush_res;
  fflags_t                a_flags;
  fflags_t                r_flags;

  rp_align #(.FRAC_W(FRAC_W), .EFLD_W(EFLD_W), .EIN_W(EIN_W)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_exp      (in_exp),
    .in_sig      (in_sig),
    .in_mode     (rmode_e'(in_rmode)),
    .in_ftz      (in_ftz),
    .in_trap     (in_uf_trap),
    .a_valid     (a_valid),
    .a_sign      (a_sign),
    .a_exp       (a_exp),
    .a_sig       (a_sig),
    .a_mode      (a_mode),
    .a_trap      (a_trap),
    .a_flush     (a_flush),
    .a_flush_res (a_flush_res),
    .a_flags     (a_flags)
  );

  rp_round_pack #(.FRAC_W(FRAC_W), .EFLD_W(EFLD_W), .EIN_W(EIN_W)) u_round (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_valid     (a_valid),
    .a_sign      (a_sign),
    .a_exp       (a_exp),
    .a_sig       (a_sig),
    .a_mode      (a_mode),
    .a_trap      (a_trap),
    .a_flush     (a_flush),
    .a_flush_res (a_flush_res),
    .a_flags     (a_flags),
    .r_valid     (out_valid),
    .r_result    (out_result),
    .r_flags     (r_flags)
  );

  assign out_inexact   = r_flags.ix;
  assign out_underflow = r_flags.uf;
  assign out_overflow  = r_flags.ov;

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R1
  AST_FLUSH_TINY_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ftz && ($signed(in_exp) < (1 - EBIAS)) |-> ##2
      (out_result[TOT_W-2:0] <= (TOT_W-1)'(1)) && out_underflow && out_inexact && !out_overflow); // R6

endmodule

// File: tb/sim_fp64_round_pack.sv
module sim_fp64_round_pack;

  localparam int NV = 34;
  // {req[8], sign, exp[13], sig[56], mode[2], ftz, trap, result[64], flags{ix,uf,ov}}
  localparam logic [148:0] VEC [NV] = '{
    {8'd2,  1'b0, 13'sd0,     56'h80000000000000, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b000}, // R2 one
    {8'd2,  1'b1, 13'sd0,     56'hC0000000000000, 2'd0, 1'b0, 1'b0, 64'hBFF8000000000000, 3'b000}, // R2 -1.5
    {8'd3,  1'b0, 13'sd0,     56'h80000000000004, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b100}, // R3 tie even stays
    {8'd3,  1'b0, 13'sd0,     56'h8000000000000C, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000002, 3'b100}, // R3 tie odd up
    {8'd3,  1'b0, 13'sd0,     56'h80000000000007, 2'd1, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b100}, // R3 toward zero
    {8'd3,  1'b0, 13'sd0,     56'h80000000000001, 2'd2, 1'b0, 1'b0, 64'h3FF0000000000001, 3'b100}, // R3 up positive
    {8'd3,  1'b1, 13'sd0,     56'h80000000000001, 2'd2, 1'b0, 1'b0, 64'hBFF0000000000000, 3'b100}, // R3 up negative
    {8'd3,  1'b1, 13'sd0,     56'h80000000000001, 2'd3, 1'b0, 1'b0, 64'hBFF0000000000001, 3'b100}, // R3 down negative
    {8'd4,  1'b0, 13'sd0,     56'hFFFFFFFFFFFFFC, 2'd0, 1'b0, 1'b0, 64'h4000000000000000, 3'b100}, // R4 carry
    {8'd5,  1'b0, 13'sd1023,  56'hFFFFFFFFFFFFFF, 2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101}, // R5 carry into overflow
    {8'd5,  1'b1, 13'sd1024,  56'h80000000000000, 2'd1, 1'b0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101}, // R5 zero mode
    {8'd5,  1'b1, 13'sd1024,  56'h80000000000000, 2'd2, 1'b0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101}, // R5 up negative
    {8'd5,  1'b0, 13'sd1024,  56'h80000000000000, 2'd2, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101}, // R5 up positive
    {8'd5,  1'b0, 13'sd1024,  56'h80000000000000, 2'd3, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101}, // R5 down positive
    {8'd5,  1'b1, 13'sd1024,  56'h80000000000000, 2'd3, 1'b0, 1'b0, 64'hFFF0000000000000, 3'b101}, // R5 down negative
    {8'd2,  1'b0, 13'sd1023,  56'hFFFFFFFFFFFFF8, 2'd0, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b000}, // R2 largest exact
    {8'd6,  1'b0, -13'sd1023, 56'h80000000000000, 2'd0, 1'b1, 1'b0, 64'h0000000000000000, 3'b110}, // R6
    {8'd6,  1'b1, -13'sd1023, 56'h80000000000000, 2'd1, 1'b1, 1'b0, 64'h8000000000000000, 3'b110}, // R6
    {8'd6,  1'b0, -13'sd1023, 56'h80000000000000, 2'd2, 1'b1, 1'b0, 64'h0000000000000001, 3'b110}, // R6
    {8'd6,  1'b1, -13'sd1023, 56'h80000000000000, 2'd2, 1'b1, 1'b0, 64'h8000000000000000, 3'b110}, // R6
    {8'd6,  1'b0, -13'sd1023, 56'h80000000000000, 2'd3, 1'b1, 1'b0, 64'h0000000000000000, 3'b110}, // R6
    {8'd6,  1'b1, -13'sd1023, 56'h80000000000000, 2'd3, 1'b1, 1'b0, 64'h8000000000000001, 3'b110}, // R6
    {8'd9,  1'b0, -13'sd1023, 56'h80000000000000, 2'd0, 1'b0, 1'b0, 64'h0008000000000000, 3'b000}, // R9 trap off
    {8'd9,  1'b0, -13'sd1023, 56'h80000000000000, 2'd0, 1'b0, 1'b1, 64'h0008000000000000, 3'b010}, // R9 trap on
    {8'd7,  1'b0, -13'sd1023, 56'h80000000000004, 2'd0, 1'b0, 1'b0, 64'h0008000000000000, 3'b110}, // R7 inexact
    {8'd7,  1'b0, -13'sd1023, 56'h80000000000001, 2'd2, 1'b0, 1'b0, 64'h0008000000000001, 3'b110}, // R7 sticky
    {8'd8,  1'b0, -13'sd1023, 56'hFFFFFFFFFFFFFC, 2'd0, 1'b0, 1'b0, 64'h0010000000000000, 3'b100}, // R8 not tiny
    {8'd8,  1'b0, -13'sd1023, 56'hFFFFFFFFFFFFFC, 2'd1, 1'b0, 1'b0, 64'h000FFFFFFFFFFFFF, 3'b110}, // R8 no carry
    {8'd7,  1'b0, -13'sd1023, 56'hFFFFFFFFFFFFF8, 2'd0, 1'b0, 1'b0, 64'h0010000000000000, 3'b110}, // R7 round to normal
    {8'd10, 1'b0, -13'sd4000, 56'h80000000000000, 2'd2, 1'b0, 1'b0, 64'h0000000000000001, 3'b110}, // R10
    {8'd10, 1'b0, -13'sd4000, 56'h80000000000000, 2'd0, 1'b0, 1'b0, 64'h0000000000000000, 3'b110}, // R10
    {8'd10, 1'b1, -13'sd1078, 56'h80000000000000, 2'd3, 1'b0, 1'b0, 64'h8000000000000001, 3'b110}, // R10
    {8'd9,  1'b0, 13'sd0,     56'h80000000000000, 2'd0, 1'b0, 1'b1, 64'h3FF0000000000000, 3'b000}, // R9 normal
    {8'd6,  1'b0, -13'sd1022, 56'h80000000000000, 2'd0, 1'b1, 1'b0, 64'h0010000000000000, 3'b000}  // R6 in range
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [12:0] in_exp = '0;
  logic [55:0] in_sig = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_ftz = 1'b0;
  logic        in_uf_trap = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_inexact;
  logic        out_underflow;
  logic        out_overflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp64_round_pack u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sign       (in_sign),
    .in_exp        (in_exp),
    .in_sig        (in_sig),
    .in_rmode      (in_rmode),
    .in_ftz        (in_ftz),
    .in_uf_trap    (in_uf_trap),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_inexact   (out_inexact),
    .out_underflow (out_underflow),
    .out_overflow  (out_overflow)
  );

  task automatic drive(input logic [148:0] v);
    in_valid   = 1'b1;
    in_sign    = v[140];
    in_exp     = v[139:127];
    in_sig     = v[126:71];
    in_rmode   = v[70:69];
    in_ftz     = v[68];
    in_uf_trap = v[67];
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s out_valid: actual %b expected %b", req, act, exp_v);
    end
  endtask

  task automatic check_vec(input logic [148:0] v);
    checks++;
    if (out_valid !== 1'b1 || out_result !== v[66:3] ||
        {out_inexact, out_underflow, out_overflow} !== v[2:0]) begin
      errors++;
      $display("FAIL R%0d: actual v=%b res=%h flags=%b expected v=1 res=%h flags=%b",
               v[148:141], out_valid, out_result,
               {out_inexact, out_underflow, out_overflow}, v[66:3], v[2:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'h0 ||
        {out_inexact, out_underflow, out_overflow} !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset: actual v=%b res=%h flags=%b expected 0 0 000", out_valid,
               out_result, {out_inexact, out_underflow, out_overflow});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_vec(VEC[i]);
    end

    // R1 latency: low one cycle after, high two cycles after, low three after
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R1 +1", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R1 +2", out_valid, 1'b1);
    @(negedge clk);
    check_bit("R1 +3", out_valid, 1'b0);

    // R1 back to back: R3 tie case followed by R4/R5 carry into overflow
    @(negedge clk);
    drive(VEC[3]);
    @(negedge clk);
    drive(VEC[9]);
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(VEC[3]);
    @(negedge clk);
    check_vec(VEC[9]);

    // R8 and R6 back to back: boundary carry then flush in the same stream
    @(negedge clk);
    drive(VEC[26]);
    @(negedge clk);
    drive(VEC[21]);
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(VEC[26]);
    @(negedge clk);
    check_vec(VEC[21]);

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule